// File: doc/BRIEF.md
# Automatic Software Flow Controller

This block sits between a UART receive FIFO and the serializer. It watches how full the receive FIFO is and decides by itself when to ask the transmitter to send an XOFF character, so that the far end stops sending. It later asks for an XON character once the FIFO has drained. XOFF is not requested the moment the fill level reaches the chosen trigger. The level must first stay at or above the trigger for a wait of two character times, counted in baud ticks for the current frame format. XON is requested at a drain level that depends on the selected trigger.

On the receive side, the block inspects every incoming character before it reaches the FIFO. A character equal to the programmed XOFF sets a transmit-pause flag for the local serializer. A character equal to the programmed XON clears that flag. Neither character is written to the FIFO. All other characters are forwarded as a FIFO write strobe with one cycle of latency. When the automatic mode is off, the block forwards every character and makes no new requests.

Top module: `flow_pacer`

## Requirements
- R1: While `rst` is high and after it is released, `fc_req`, `tx_pause` and `rx_wr` are low until a stimulus calls for them.
- R2: `trig_sel` picks the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters. No XOFF is requested while `fifo_cnt` stays below that level.
- R3: Once `fifo_cnt` is at or above the trigger, the block waits for a number of `baud_tick` pulses. That number is twice (7 + `word_len` + `parity_en` + `stop2`): start bit, 5 + `word_len` data bits, parity, and 1 + `stop2` stop bits, taken twice. Counting starts with the cycle after the crossing is seen. `fc_req` rises with `fc_char` = `xoff_char` on the cycle after the last of those ticks.
- R4: If `fifo_cnt` falls below the trigger before the wait ends, the tick count is discarded. A later crossing starts the full wait again.
- R5: XON is requested only after an XOFF request was accepted. It is requested one cycle after `fifo_cnt` is at or below the resume level: 0, 1, 4 or 8 for `trig_sel` 0, 1, 2 or 3.
- R6: `fc_req` and `fc_char` hold until `fc_ack` is sampled high. `fc_req` is low on the following cycle.
- R7: With `auto_en` low, no new request is raised, and a wait in progress is abandoned with its count cleared.
- R8: A received character is compared with the XON and XOFF characters on its low 5 + `word_len` bits only. When `auto_en` is high, a match is not written to the FIFO.
- R9: A matched XOFF sets `tx_pause` on the next cycle. A matched XON clears it. `tx_pause` is cleared while `auto_en` is low. XOFF wins when both characters match.
- R10: Any other received character gives `rx_wr` high for one cycle, one cycle after `rx_valid`, with `rx_wr_data` equal to the received byte. With `auto_en` low, every character is passed through this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Enables automatic flow control |
| trig_sel | input | 2 | Trigger level select |
| fifo_cnt | input | CNT_W | Current receive FIFO occupancy |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Frame carries a parity bit |
| stop2 | input | 1 | Frame carries two stop bits |
| baud_tick | input | 1 | One pulse per bit period |
| xon_char | input | CHAR_W | Programmed XON character |
| xoff_char | input | CHAR_W | Programmed XOFF character |
| fc_ack | input | 1 | Serializer takes the flow-control character |
| fc_req | output | 1 | Request to insert a flow-control character |
| fc_char | output | CHAR_W | Character to insert |
| tx_pause | output | 1 | Remote end asked the local transmitter to pause |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CHAR_W | Received character |
| rx_wr | output | 1 | Filtered FIFO write strobe |
| rx_wr_data | output | CHAR_W | Data for the FIFO write |

## Verification
Receive results (`rx_wr`, `tx_pause`) are due one cycle after `rx_valid`. An XOFF request is due on the cycle after the last counted baud tick. An XON request is due one cycle after the drain level is presented. `fc_req` falls one cycle after `fc_ack`. Inputs are driven on falling edges, so each tick or strobe spans exactly one rising edge, and every check samples on the next falling edge. Each wait is probed one tick short and then at its exact end. A scoreboard queue holds every expected FIFO write and every expected request character, and it must be empty at the end.

// File: rtl/flow_pkg.sv
`timescale 1ns/1ps
package flow_pkg;
  localparam int CHAR_W = 8;
  localparam int LVL_W  = 5;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_WAIT,
    FS_SEND_OFF,
    FS_PAUSED,
    FS_SEND_ON
  } fs_t;

  function automatic logic [LVL_W-1:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return LVL_W'(1);
      2'd1:    return LVL_W'(4);
      2'd2:    return LVL_W'(8);
      default: return LVL_W'(14);
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] resume_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return LVL_W'(0);
      2'd1:    return LVL_W'(1);
      2'd2:    return LVL_W'(4);
      default: return LVL_W'(8);
    endcase
  endfunction

  // keeps the low 5 + wl bits of a character
  function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] wl);
    return {CHAR_W{1'b1}} >> (CHAR_W - 5 - int'(wl));
  endfunction
endpackage

// File: rtl/fc_char_timer.sv
`timescale 1ns/1ps
module fc_char_timer #(
  parameter int DLY_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       stop2,
  output logic       expire
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] limit;

  // two frames: start + (5+wl) data + parity + (1+stop2) stop
  always_comb begin
    limit  = DLY_W'(2 * (7 + int'(word_len) + int'(parity_en) + int'(stop2)));
    expire = run && tick && (cnt_q == limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fc_sequencer.sv
`timescale 1ns/1ps
module fc_sequencer
  import flow_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic [1:0]        trig_sel,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              expire,
  input  logic              fc_ack,
  output logic              run,
  output logic              fc_req,
  output logic [CHAR_W-1:0] fc_char
);
  localparam int CW = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  fs_t state_q, state_d;
  logic [CHAR_W-1:0] char_q;
  logic [CW-1:0] cnt_x, trig_x, resume_x;
  logic above, drained;

  always_comb begin
    cnt_x    = CW'(fifo_cnt);
    trig_x   = CW'(trig_level(trig_sel));
    resume_x = CW'(resume_level(trig_sel));
    above    = cnt_x >= trig_x;
    drained  = cnt_x <= resume_x;
    run      = (state_q == FS_WAIT) && auto_en && above;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      FS_IDLE:     if (auto_en && above) state_d = FS_WAIT;
      FS_WAIT:     if (!run) state_d = FS_IDLE;
                   else if (expire) state_d = FS_SEND_OFF;
      FS_SEND_OFF: if (fc_ack) state_d = FS_PAUSED;
      FS_PAUSED:   if (auto_en && drained) state_d = FS_SEND_ON;
      FS_SEND_ON:  if (fc_ack) state_d = FS_IDLE;
      default:     state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == FS_WAIT && state_d == FS_SEND_OFF) char_q <= xoff_char;
      if (state_q == FS_PAUSED && state_d == FS_SEND_ON) char_q <= xon_char;
    end
  end

  assign fc_req  = (state_q == FS_SEND_OFF) || (state_q == FS_SEND_ON);
  assign fc_char = char_q;
endmodule

// File: rtl/fc_rx_filter.sv
`timescale 1ns/1ps
module fc_rx_filter
  import flow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic [1:0]        word_len,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_wr,
  output logic [CHAR_W-1:0] rx_wr_data,
  output logic              tx_pause
);
  logic [CHAR_W-1:0] mask;
  logic hit_off, hit_on;

  always_comb begin
    mask    = char_mask(word_len);
    hit_off = auto_en && rx_valid && (((rx_data ^ xoff_char) & mask) == '0);
    hit_on  = auto_en && rx_valid && !hit_off &&
              (((rx_data ^ xon_char) & mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_wr      <= 1'b0;
      rx_wr_data <= '0;
      tx_pause   <= 1'b0;
    end else begin
      rx_wr <= rx_valid && !hit_off && !hit_on;
      if (rx_valid) rx_wr_data <= rx_data;
      if (!auto_en)     tx_pause <= 1'b0;
      else if (hit_off) tx_pause <= 1'b1;
      else if (hit_on)  tx_pause <= 1'b0;
    end
  end
endmodule

// File: rtl/flow_pacer.sv
`timescale 1ns/1ps
module flow_pacer
  import flow_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DLY_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic [1:0]        trig_sel,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic [1:0]        word_len,
  input  logic              parity_en,
  input  logic              stop2,
  input  logic              baud_tick,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              fc_ack,
  output logic              fc_req,
  output logic [CHAR_W-1:0] fc_char,
  output logic              tx_pause,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_wr,
  output logic [CHAR_W-1:0] rx_wr_data
);
  logic run, expire;

  fc_char_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .tick(baud_tick),
    .word_len(word_len), .parity_en(parity_en), .stop2(stop2),
    .expire(expire)
  );

  fc_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .auto_en(auto_en), .trig_sel(trig_sel),
    .fifo_cnt(fifo_cnt), .xon_char(xon_char), .xoff_char(xoff_char),
    .expire(expire), .fc_ack(fc_ack), .run(run),
    .fc_req(fc_req), .fc_char(fc_char)
  );

  fc_rx_filter u_rx (
    .clk(clk), .rst(rst), .auto_en(auto_en), .word_len(word_len),
    .xon_char(xon_char), .xoff_char(xoff_char),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_wr(rx_wr), .rx_wr_data(rx_wr_data), .tx_pause(tx_pause)
  );
endmodule

// File: rtl/flow_pacer_chk.sv
`timescale 1ns/1ps
module flow_pacer_chk
  import flow_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              auto_en,
  input logic [1:0]        word_len,
  input logic [CHAR_W-1:0] xon_char,
  input logic [CHAR_W-1:0] xoff_char,
  input logic              fc_ack,
  input logic              fc_req,
  input logic [CHAR_W-1:0] fc_char,
  input logic              tx_pause,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_data,
  input logic              rx_wr,
  input logic [CHAR_W-1:0] rx_wr_data
);
  logic [CHAR_W-1:0] m;
  logic is_off, is_on;
  assign m      = char_mask(word_len);
  assign is_off = ((rx_data ^ xoff_char) & m) == '0;
  assign is_on  = ((rx_data ^ xon_char) & m) == '0;

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    fc_req && !fc_ack |=> fc_req && $stable(fc_char));

  p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
    fc_req && fc_ack |=> !fc_req);

  p_no_new_req_r7: assert property (@(posedge clk) disable iff (rst)
    !auto_en && !fc_req |=> !fc_req);

  p_kept_out_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid && auto_en && (is_off || is_on) |=> !rx_wr);

  p_pause_set_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid && auto_en && is_off |=> tx_pause);

  p_pause_off_r9: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> !tx_pause);

  p_pass_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !auto_en |=> rx_wr && rx_wr_data == $past(rx_data));
endmodule

bind flow_pacer flow_pacer_chk u_chk (
  .clk(clk), .rst(rst), .auto_en(auto_en), .word_len(word_len),
  .xon_char(xon_char), .xoff_char(xoff_char), .fc_ack(fc_ack),
  .fc_req(fc_req), .fc_char(fc_char), .tx_pause(tx_pause),
  .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_wr(rx_wr), .rx_wr_data(rx_wr_data)
);

// File: tb/test_flow_pacer.sv
`timescale 1ns/1ps
module test_flow_pacer;
  localparam int CNT_W = 5;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, auto_en = 1'b0, parity_en = 1'b0, stop2 = 1'b0;
  logic baud_tick = 1'b0, fc_ack = 1'b0, rx_valid = 1'b0;
  logic [1:0] trig_sel = 2'd0, word_len = 2'd3;
  logic [CNT_W-1:0] fifo_cnt = '0;
  logic [7:0] xon_char = XON, xoff_char = XOFF, rx_data = '0;
  logic fc_req, tx_pause, rx_wr;
  logic [7:0] fc_char, rx_wr_data;

  flow_pacer #(.CNT_W(CNT_W)) i_flow_pacer (
    .clk(clk), .rst(rst), .auto_en(auto_en), .trig_sel(trig_sel),
    .fifo_cnt(fifo_cnt), .word_len(word_len), .parity_en(parity_en),
    .stop2(stop2), .baud_tick(baud_tick), .xon_char(xon_char),
    .xoff_char(xoff_char), .fc_ack(fc_ack), .fc_req(fc_req),
    .fc_char(fc_char), .tx_pause(tx_pause), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_wr(rx_wr), .rx_wr_data(rx_wr_data)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_rx_q[$];
  logic [7:0] exp_fc_q[$];
  logic req_prev = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin : mon
    logic [7:0] e;
    if (!rst) begin
      if (rx_wr) begin
        if (exp_rx_q.size() == 0) check(1'b0, "R8 unexpected FIFO write", rx_wr_data, -1);
        else begin
          e = exp_rx_q.pop_front();
          check(rx_wr_data == e, "R10 write data", rx_wr_data, e);
        end
      end
      if (fc_req && !req_prev) begin
        if (exp_fc_q.size() == 0) check(1'b0, "R7 unexpected request", fc_char, -1);
        else begin
          e = exp_fc_q.pop_front();
          check(fc_char == e, "R3 request char", fc_char, e);
        end
      end
      req_prev = fc_req;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
    end
  endtask

  task automatic ack();
    @(negedge clk) fc_ack = 1'b1;
    @(negedge clk) fc_ack = 1'b0;
    check(fc_req == 1'b0, "R6 drop after ack", fc_req, 0);
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = d; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  // XOFF after exactly 'lim' ticks, then XON at the drain level
  task automatic cycle_flow(input int lvl, input int lim, input int rlvl, input string tag);
    fifo_cnt = CNT_W'(lvl - 1);
    tick(lim + 5);
    check(fc_req == 1'b0, {tag, " R2 below trigger"}, fc_req, 0);
    fifo_cnt = CNT_W'(lvl);
    exp_fc_q.push_back(XOFF);
    tick(lim - 1);
    check(fc_req == 1'b0, {tag, " R3 one tick short"}, fc_req, 0);
    tick(1);
    check(fc_req == 1'b1, {tag, " R3 xoff due"}, fc_req, 1);
    cyc(3);
    check(fc_req == 1'b1 && fc_char == XOFF, {tag, " R6 held"}, fc_char, XOFF);
    ack();
    fifo_cnt = CNT_W'(rlvl + 1);
    cyc(3);
    check(fc_req == 1'b0, {tag, " R5 not yet drained"}, fc_req, 0);
    fifo_cnt = CNT_W'(rlvl);
    exp_fc_q.push_back(XON);
    cyc(1);
    check(fc_req == 1'b1 && fc_char == XON, {tag, " R5 xon due"}, fc_char, XON);
    ack();
    fifo_cnt = '0;
    cyc(2);
  endtask

  initial begin
    cyc(3);
    check(fc_req == 0 && tx_pause == 0 && rx_wr == 0, "R1 in reset", fc_req, 0);
    rst = 1'b0;
    cyc(2);
    check(fc_req == 0 && tx_pause == 0 && rx_wr == 0, "R1 after reset", tx_pause, 0);

    auto_en = 1'b1;
    // 8N1: limit 20, trigger 4
    trig_sel = 2'd1; word_len = 2'd3; parity_en = 0; stop2 = 0;
    cycle_flow(4, 20, 1, "t4");
    // 7N1: limit 18, trigger 14 and 8
    trig_sel = 2'd3; word_len = 2'd2;
    cycle_flow(14, 18, 8, "t14");
    trig_sel = 2'd2;
    cycle_flow(8, 18, 4, "t8");

    // R4: 5E2 limit 18, trigger 1, wait interrupted
    trig_sel = 2'd0; word_len = 2'd0; parity_en = 1; stop2 = 1;
    fifo_cnt = 1;
    tick(10);
    fifo_cnt = 0;
    cyc(2);
    fifo_cnt = 1;
    tick(17);
    check(fc_req == 1'b0, "R4 count restarted", fc_req, 0);
    exp_fc_q.push_back(XOFF);
    tick(1);
    check(fc_req == 1'b1, "R4 full wait done", fc_req, 1);
    ack();
    exp_fc_q.push_back(XON);
    fifo_cnt = 0;
    cyc(1);
    check(fc_req == 1'b1 && fc_char == XON, "R5 xon at zero", fc_char, XON);
    ack();

    // R7: disabled
    trig_sel = 2'd2; word_len = 2'd2; parity_en = 0; stop2 = 0;
    auto_en = 1'b0;
    fifo_cnt = 14;
    tick(30);
    check(fc_req == 1'b0, "R7 no request when off", fc_req, 0);
    auto_en = 1'b1;
    tick(10);
    auto_en = 1'b0;
    cyc(2);
    auto_en = 1'b1;
    tick(17);
    check(fc_req == 1'b0, "R7 wait abandoned", fc_req, 0);
    exp_fc_q.push_back(XOFF);
    tick(1);
    check(fc_req == 1'b1, "R7 xoff after re-enable", fc_req, 1);
    ack();
    exp_fc_q.push_back(XON);
    fifo_cnt = 0;
    cyc(1);
    check(fc_req == 1'b1, "R5 xon after re-enable", fc_req, 1);
    ack();

    // receive filtering
    word_len = 2'd3;
    exp_rx_q.push_back(8'h41);
    rx_send(8'h41);
    check(tx_pause == 1'b0, "R10 plain char", tx_pause, 0);
    rx_send(XOFF);
    check(tx_pause == 1'b1, "R9 xoff sets pause", tx_pause, 1);
    rx_send(XON);
    check(tx_pause == 1'b0, "R9 xon clears pause", tx_pause, 0);
    word_len = 2'd2;
    rx_send(8'h93);
    check(tx_pause == 1'b1, "R8 masked xoff match", tx_pause, 1);
    word_len = 2'd3;
    exp_rx_q.push_back(8'h93);
    rx_send(8'h93);
    check(tx_pause == 1'b1, "R8 full width no match", tx_pause, 1);
    auto_en = 1'b0;
    cyc(1);
    check(tx_pause == 1'b0, "R9 cleared when off", tx_pause, 0);
    exp_rx_q.push_back(XOFF);
    rx_send(XOFF);
    check(tx_pause == 1'b0, "R10 pass through when off", tx_pause, 0);

    cyc(3);
    check(exp_rx_q.size() == 0, "R10 writes missing", exp_rx_q.size(), 0);
    check(exp_fc_q.size() == 0, "R3 requests missing", exp_fc_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule